// File: doc/BRIEF.md
# SPI Master Controller with Word Queues

This block is a memory-mapped SPI bus master. Software queues up to four transmit words through a data register. While the controller is in its run mode, it shifts each word out on the serial data output. In the same serial clock periods it captures one word from the serial input and places it in a four-word receive queue. Reading the data register drains that queue.

Words are 8 or 16 bits long and are sent in either bit order. Clock polarity and clock phase are selectable. A divider sets how many base clock cycles each serial bit lasts. Chip select lives outside the block.

Configuration changes are accepted only while the controller is parked in its setup mode. A single write that selects setup mode and also sets the flush bit empties both queues. A status register reports queue fills and idleness. It also reports whether the receive fill has reached a programmable threshold. That threshold flag, gated by an enable bit, drives an interrupt line.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the mode field reads setup (register 0x00 reads 0x40), both queues are empty, status (0x14) reads 0x4, `sck` is low and `irq` is low.
- R2: The registers are decoded at byte offsets 0x00 (mode), 0x04 (frame control), 0x08 (rate/length), 0x14 (status) and 0x18 (data). Mode bits 7:6 hold 01 for setup and 10 for run. Rate/length reads back the divider in bits 15:8 and the word length (8 or 16) in bits 4:0.
- R3: A write to 0x00 whose bits 7:6 are 01 and whose bit 0 is 1 empties both the transmit and the receive queue.
- R4: Writes to 0x04 and 0x08 change nothing while the mode is run; their read-back values stay as before.
- R5: Each serial bit lasts n+1 base clock cycles, where n is the divider from 0x08 bits 15:8; a written n of 0 is stored and used as 1.
- R6: A length field (0x08 bits 4:0) of 16 selects 16-bit words; any other value selects 8-bit words, which send data bits 7:0 and receive into bits 7:0 with bits 15:8 read as zero.
- R7: Frame control bit 2 set sends and receives the most significant bit first; clear sends the least significant bit first.
- R8: Frame control bit 0 is the idle level of `sck`. With bit 1 (phase) clear, the slave samples on the first edge of each bit; with it set, on the second edge. `mosi` changes only at bit boundaries and `miso` is captured at the end of each bit.
- R9: A write to 0x18 queues a transmit word unless the transmit queue already holds 4, in which case it is dropped. A read of 0x18 returns and removes the oldest received word, or returns 0 and removes nothing when the receive queue is empty.
- R10: Every transmitted word produces exactly one received word in order; a transfer does not start while the receive queue is full, so no received word is lost.
- R11: Status bits 13:11 give the transmit fill, bits 10:8 the receive fill, bit 2 is 1 when the transmit queue is empty and no word is shifting, and bit 14 is 1 while the receive fill is at least frame control bits 13:12 plus one.
- R12: `irq` equals status bit 14 AND frame control bit 9, registered one cycle, and falls once reads drop the receive fill below the threshold.
- R13: No transfer starts while the mode is not run; queued transmit words stay queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Receive-threshold interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest state to reach from the ports is a receive queue that is full while transmit words wait behind it. The engine must stall there without dropping or overwriting anything. The stimulus sends four words without reading any of them back, then queues two more. It reads the status fills to show the transmit words held back. It then pops received words one at a time and watches exactly one waiting word go out per freed slot. A behavioural slave in the bench follows every serial edge for all four polarity and phase combinations. It checks the bit spacing and both data directions.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned DIV_W  = 8;

  localparam logic [ADDR_W-1:0] OFS_MODE = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_FRM  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_RATE = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_DATA = 5'h18;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_CFG = 2'b01,
    MODE_RUN = 2'b10,
    MODE_RSV = 2'b11
  } op_mode_e;

  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic             msb_first;
    logic             wide;
    logic [DIV_W-1:0] div;
  } link_cfg_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  a_r9_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> (count == $past(count)));
  a_r9_empty_pop_dropped: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !clr) |=> (count == '0));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_fifo_pkg::*;
#(
  parameter int unsigned WW = WORD_W,
  parameter int unsigned DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  link_cfg_t     cfg,
  input  logic          tx_valid,
  input  logic [WW-1:0] tx_word,
  input  logic          rx_room,
  input  logic          miso,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [WW-1:0] rx_word,
  output logic          busy,
  output logic          sck,
  output logic          mosi
);
  localparam int unsigned IDX_W = $clog2(WW) + 1;

  logic [DW-1:0]    cnt;
  logic [IDX_W-1:0] bidx, len;
  logic [WW-1:0]    txw, rxw, rx_next;
  logic [DW:0]      div_eff, hi_start;
  logic             start, bit_end, last_bit;

  function automatic logic [IDX_W-2:0] pos(input logic [IDX_W-1:0] i,
                                           input logic [IDX_W-1:0] l,
                                           input logic m);
    logic [IDX_W-1:0] t;
    t = m ? (l - 1'b1 - i) : i;
    return t[IDX_W-2:0];
  endfunction

  assign div_eff  = (cfg.div == '0) ? (DW+1)'(1) : {1'b0, cfg.div};
  assign hi_start = (div_eff + 1'b1) >> 1;
  assign len      = cfg.wide ? IDX_W'(WW) : IDX_W'(WW/2);
  assign start    = !busy && enable && tx_valid && rx_room;
  assign bit_end  = busy && ({1'b0, cnt} == div_eff);
  assign last_bit = (bidx == len - 1'b1);
  assign tx_pop   = start;
  assign rx_push  = bit_end && last_bit;
  assign rx_word  = rx_next;

  always_comb begin
    rx_next = rxw;
    rx_next[pos(bidx, len, cfg.msb_first)] = miso;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      bidx <= '0;
      txw  <= '0;
      rxw  <= '0;
      sck  <= 1'b0;
      mosi <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      bidx <= '0;
      txw  <= tx_word;
      rxw  <= '0;
      mosi <= tx_word[pos('0, len, cfg.msb_first)];
      sck  <= cfg.cpol ^ cfg.cpha;
    end else if (busy) begin
      if (bit_end) begin
        rxw <= rx_next;
        cnt <= '0;
        if (last_bit) begin
          busy <= 1'b0;
          sck  <= cfg.cpol;
        end else begin
          bidx <= bidx + 1'b1;
          mosi <= txw[pos(bidx + 1'b1, len, cfg.msb_first)];
          sck  <= cfg.cpol ^ cfg.cpha;
        end
      end else begin
        cnt <= cnt + 1'b1;
        sck <= cfg.cpol ^ cfg.cpha ^ (({1'b0, cnt} + 1'b1) >= hi_start);
      end
    end else begin
      sck <= cfg.cpol;
    end
  end

  a_r8_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && cfg.cpol == $past(cfg.cpol)) |-> (sck == cfg.cpol));
  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> ({1'b0, cnt} <= div_eff));
  a_r8_mosi_at_boundary: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && cnt != '0) |-> $stable(mosi));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  op_mode_e         mode;
  link_cfg_t        cfg;
  logic [1:0]       rx_lvl;
  logic             rx_ie;
  logic             flush, tx_push, rx_pop, eng_pop, eng_push, busy;
  logic             tx_full, tx_empty, rx_full, rx_empty, thr_hit, idle;
  logic [WORD_W-1:0] tx_dout, rx_dout, eng_rx;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             unused_bits;

  assign unused_bits = ^{bus_wdata[31:16], bus_wdata[5], tx_full};
  assign flush   = bus_wr && bus_addr == OFS_MODE && bus_wdata[7:6] == MODE_CFG && bus_wdata[0];
  assign tx_push = bus_wr && bus_addr == OFS_DATA;
  assign rx_pop  = bus_rd && bus_addr == OFS_DATA;
  assign thr_hit = (32'(rx_cnt) >= 32'(rx_lvl) + 1);
  assign idle    = !busy && tx_empty;

  spi_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(flush), .push(tx_push), .din(bus_wdata[WORD_W-1:0]),
    .pop(eng_pop), .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spi_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(flush), .push(eng_push), .din(eng_rx),
    .pop(rx_pop), .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spi_shift_engine u_eng (
    .clk(clk), .rst(rst), .enable(mode == MODE_RUN), .cfg(cfg),
    .tx_valid(!tx_empty), .tx_word(tx_dout), .rx_room(!rx_full), .miso(miso),
    .tx_pop(eng_pop), .rx_push(eng_push), .rx_word(eng_rx), .busy(busy),
    .sck(sck), .mosi(mosi));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= MODE_CFG;
      cfg    <= '{cpol: 1'b0, cpha: 1'b0, msb_first: 1'b0, wide: 1'b0, div: DIV_W'(1)};
      rx_lvl <= '0;
      rx_ie  <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_MODE) mode <= op_mode_e'(bus_wdata[7:6]);
      if (mode == MODE_CFG && bus_addr == OFS_FRM) begin
        cfg.cpol      <= bus_wdata[0];
        cfg.cpha      <= bus_wdata[1];
        cfg.msb_first <= bus_wdata[2];
        rx_ie         <= bus_wdata[9];
        rx_lvl        <= bus_wdata[13:12];
      end
      if (mode == MODE_CFG && bus_addr == OFS_RATE) begin
        cfg.div  <= (bus_wdata[15:8] == '0) ? DIV_W'(1) : bus_wdata[15:8];
        cfg.wide <= (bus_wdata[4:0] == 5'd16);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= thr_hit && rx_ie;
      if (bus_rd) begin
        case (bus_addr)
          OFS_MODE: bus_rdata <= {24'b0, mode, 6'b0};
          OFS_FRM:  bus_rdata <= {18'b0, rx_lvl, 2'b0, rx_ie, 6'b0,
                                  cfg.msb_first, cfg.cpha, cfg.cpol};
          OFS_RATE: bus_rdata <= {16'b0, cfg.div, 3'b0, cfg.wide ? 5'd16 : 5'd8};
          OFS_STAT: bus_rdata <= {16'b0, 1'b0, thr_hit, 3'(tx_cnt), 3'(rx_cnt),
                                  5'b0, idle, 2'b0};
          OFS_DATA: bus_rdata <= rx_empty ? 32'b0 : {{(32-WORD_W){1'b0}}, rx_dout};
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  a_r12_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(rx_ie));
  a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RUN) |=> ($stable(cfg) && $stable(rx_lvl) && $stable(rx_ie)));
  a_r3_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (tx_cnt == '0 && rx_cnt == '0));
  a_r10_no_rx_drop: assert property (@(posedge clk) disable iff (rst)
    eng_push |-> !rx_full);
  a_r13_run_only: assert property (@(posedge clk) disable iff (rst)
    eng_pop |-> (mode == MODE_RUN));
endmodule

// File: tb/sim_spi_fifo_master.sv
module sim_spi_fifo_master;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, sck, mosi, miso = 1'b0;

  always #2 clk = ~clk;

  spi_fifo_master u0 (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso));

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  // bench mirror of the programmed link
  logic s_on = 0, s_cpol = 0, s_cpha = 0, s_msb = 0, s_wide = 0;
  int   s_div = 1, s_cnt = 0, last_t = 0;
  logic [15:0] s_cap = '0;
  logic [15:0] tx_q[$], s_out[$], rx_q[$];

  function automatic int slen();
    return s_wide ? 16 : 8;
  endfunction
  function automatic int spos(int c);
    return s_msb ? slen() - 1 - c : c;
  endfunction
  function automatic logic [15:0] smask(logic [15:0] w);
    return s_wide ? w : {8'h00, w[7:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural slave, reacts to every serial clock change
  always @(sck) begin
    #1;
    if (s_on) begin
      if ((sck != s_cpol) ^ s_cpha) begin
        if (s_cnt != 0) chk("R5 bit spacing", cyc - last_t, s_div + 1);
        last_t = cyc;
        s_cap[spos(s_cnt)] = mosi;
        s_cnt++;
        if (s_cnt == slen()) begin
          s_cnt = 0;
          if (tx_q.size() == 0) chk("R10 unexpected word", {16'h0, s_cap}, 32'hFFFF_FFFF);
          else chk("R6/R7/R8 slave received", {16'h0, s_cap}, {16'h0, tx_q.pop_front()});
          if (s_out.size() != 0) void'(s_out.pop_front());
          s_cap = '0;
        end
      end else begin
        miso = (s_out.size() != 0) ? s_out[0][spos(s_cnt)] : 1'b0;
      end
    end
  end

  task automatic bw(logic [4:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic br(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic setup(logic cp, logic ph, logic msb, logic wide, int div, int lvl, logic ie);
    s_on = 0;
    bw(5'h00, 32'h40);
    bw(5'h04, (lvl << 12) | (32'(ie) << 9) | (32'(msb) << 2) | (32'(ph) << 1) | 32'(cp));
    bw(5'h08, (div << 8) | (wide ? 16 : 8));
    s_cpol = cp; s_cpha = ph; s_msb = msb; s_wide = wide; s_div = (div == 0) ? 1 : div;
    repeat (4) @(negedge clk);
    s_cnt = 0; s_cap = '0; s_on = 1;
  endtask

  task automatic send(logic [15:0] w, logic [15:0] r);
    bw(5'h18, {16'h0, w});
    if (s_out.size() == 0 && s_cnt == 0 && !s_cpha) miso = r[spos(0)];
    tx_q.push_back(smask(w));
    s_out.push_back(r);
    rx_q.push_back(smask(r));
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      br(5'h14, v);
      if (v[2]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_chk(string tag);
    logic [31:0] v;
    br(5'h18, v);
    if (rx_q.size() == 0) chk(tag, v, 32'h0);
    else chk(tag, v, {16'h0, rx_q.pop_front()});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    br(5'h00, v); chk("R1 R2 mode reset", v, 32'h40);
    br(5'h14, v); chk("R1 R11 status reset", v, 32'h4);
    chk("R1 sck low", {31'h0, sck}, 32'h0);
    chk("R1 irq low", {31'h0, irq}, 32'h0);

    // 8-bit, MSB first, mode 0, divider 3, threshold 2 with interrupt
    setup(0, 0, 1, 0, 3, 1, 1);
    br(5'h08, v); chk("R2 rate readback", v, 32'h0308);
    send(16'h12A5, 16'h003C); send(16'h0081, 16'h55F0); send(16'h777E, 16'h0001);
    repeat (60) @(negedge clk);
    br(5'h14, v); chk("R13 held in setup tx fill", (v >> 11) & 7, 3);
    chk("R13 not idle", (v >> 2) & 1, 0);
    bw(5'h00, 32'h80);
    wait_idle();
    br(5'h14, v); chk("R11 rx fill", (v >> 8) & 7, 3);
    chk("R11 threshold flag", (v >> 14) & 1, 1);
    chk("R12 irq asserted", {31'h0, irq}, 1);
    bw(5'h08, 32'h0110); bw(5'h04, 32'h0003);
    br(5'h08, v); chk("R4 rate frozen in run", v, 32'h0308);
    br(5'h04, v); chk("R4 frame frozen in run", v, 32'h1204);
    pop_chk("R9 R6 rx word 0");
    pop_chk("R9 rx word 1");
    repeat (3) @(negedge clk);
    chk("R12 irq falls below threshold", {31'h0, irq}, 0);
    pop_chk("R9 rx word 2");
    br(5'h18, v); chk("R9 empty read zero", v, 32'h0);

    // 16-bit, LSB first, mode 3, divider 0 -> 1, threshold 4, no interrupt
    setup(1, 1, 0, 1, 0, 3, 0);
    br(5'h08, v); chk("R5 zero divider stored as 1", v, 32'h0110);
    chk("R8 idle level follows polarity", {31'h0, sck}, 1);
    bw(5'h00, 32'h80);
    send(16'hBEEF, 16'h1357); send(16'h0F0F, 16'hFFFF);
    send(16'h8001, 16'hA55A); send(16'h4321, 16'h0000);
    wait_idle();
    br(5'h14, v); chk("R11 rx full fill", (v >> 8) & 7, 4);
    chk("R11 threshold at 4", (v >> 14) & 1, 1);
    chk("R12 irq disabled", {31'h0, irq}, 0);
    send(16'h1111, 16'h2222); send(16'h3333, 16'h4444);
    repeat (100) @(negedge clk);
    br(5'h14, v); chk("R10 stall tx fill", (v >> 11) & 7, 2);
    chk("R10 stall rx fill", (v >> 8) & 7, 4);
    pop_chk("R10 first of full queue");
    repeat (100) @(negedge clk);
    br(5'h14, v); chk("R10 one slot one word", (v >> 11) & 7, 1);
    for (int i = 0; i < 4; i++) pop_chk("R10 in-order rx");
    wait_idle();
    pop_chk("R10 last rx");

    // all polarity/phase combinations, alternating order and length
    for (int m = 0; m < 4; m++) begin
      setup(m[1], m[0], m[0], m[1], 2 + m, 0, 1);
      send(16'hC3A1 ^ 16'(m * 16'h1111), 16'h6B2D + 16'(m));
      send(16'h0F71 + 16'(m), 16'h9E44 ^ 16'(m << 4));
      bw(5'h00, 32'h80);
      wait_idle();
      chk("R8 idle level after words", {31'h0, sck}, {31'h0, s_cpol});
      pop_chk("R8 R7 rx mode word a");
      pop_chk("R8 R7 rx mode word b");
    end

    // overflow and flush
    setup(0, 0, 1, 1, 1, 0, 1);
    for (int i = 0; i < 6; i++) bw(5'h18, 32'h100 + i);
    br(5'h14, v); chk("R9 full write dropped", (v >> 11) & 7, 4);
    bw(5'h00, 32'h41);
    br(5'h14, v); chk("R3 flush empties tx", v, 32'h4);
    send(16'hA0A0, 16'h0B0B); send(16'h1234, 16'h5678);
    bw(5'h00, 32'h80);
    wait_idle();
    br(5'h14, v); chk("R3 rx filled before flush", (v >> 8) & 7, 2);
    bw(5'h00, 32'h41);
    rx_q.delete();
    br(5'h14, v); chk("R3 flush empties rx", (v >> 8) & 7, 0);
    br(5'h18, v); chk("R3 R9 read after flush", v, 32'h0);
    repeat (3) @(negedge clk);
    chk("R12 irq after flush", {31'h0, irq}, 0);
    chk("R10 all words delivered", tx_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule